// File: doc/BRIEF.md
# Full-Speed USB Host Line Serializer

This block turns a byte buffer holding one or two ready-made packets into the sequence of line states that a full-speed USB host drives on its differential pair. A one-cycle start request sets the transfer length and an optional split position. The block then reads the buffer one byte at a time through a combinational read port. For each packet it drives a SYNC field, the payload bits least significant bit first with NRZI encoding and bit stuffing, and an end-of-packet sequence. After that it releases the line.

With a split position, a token and the data packet that follows it go out from a single start. When the byte index reaches the split position, the block closes the first packet with an end-of-packet and opens the second with a fresh SYNC. While the pair is released, the block shows the idle level that the device pull-up would produce: J when the pull-up is present, SE0 when it is absent. CRC generation, packet assembly and receive decoding belong to other blocks.

Top module: `usb_line_serializer`

## Requirements
- R1: Every line symbol is held for exactly TICKS_PER_BIT clock cycles. The first symbol appears on the cycle after the start request is accepted.
- R2: Each packet begins with eight symbols taken from SYNC_PATTERN, least significant bit first. A pattern bit of 1 drives J ({dp,dn}=2'b10) and a 0 drives K (2'b01). No NRZI is applied to these symbols. The default pattern 8'h2A gives K J K J K J K K.
- R3: Payload bytes are read at rd_addr_o and sent least significant bit first in NRZI form. A 0 bit swaps J and K; a 1 bit repeats the previous symbol. The bytes come out in address order, from 0 up to byte_count_i-1.
- R4: After STUFF_RUN (6) consecutive 1 bits, one extra transition is inserted before anything else is sent. This holds even when the byte count or the split position has just been reached.
- R5: Each packet ends with two symbols of SE0 (2'b00) and then one symbol of J. After the last packet, drive_en_o falls and busy_o falls in the same cycle.
- R6: A split_idx_i that is nonzero and less than byte_count_i closes the first packet after byte split_idx_i-1 with the sequence of R5. A fresh SYNC follows, and transmission resumes at byte split_idx_i. A split_idx_i of zero or at least byte_count_i gives a single packet.
- R7: While drive_en_o is low, dp_o follows pullup_i and dn_o is 0: J with the pull-up, SE0 without it.
- R8: busy_o rises on the cycle after an accepted start and stays high until release. A start request while busy_o is high is ignored and does not change the transfer in progress.
- R9: The run of consecutive ones used by R4 is cleared at the start of every SYNC, so the count from the first packet does not carry into the second.
- R10: dp_o and dn_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; each line symbol lasts TICKS_PER_BIT cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a transfer |
| byte_count_i | input | $clog2(MAX_BYTES+1) | Total number of bytes to send, captured at start |
| split_idx_i | input | $clog2(MAX_BYTES+1) | Byte index at which a second packet begins; zero means no split |
| pullup_i | input | 1 | Device pull-up present; sets the released line level |
| rd_addr_o | output | $clog2(MAX_BYTES+1) | Buffer address of the byte being sent |
| rd_data_i | input | 8 | Buffer byte at rd_addr_o, same cycle |
| busy_o | output | 1 | High from start until the line is released |
| drive_en_o | output | 1 | High while the block drives the pair |
| dp_o | output | 1 | D+ level |
| dn_o | output | 1 | D- level |

## Verification
The bench builds the block with its defaults: four ticks per symbol, a sixteen-byte buffer, SYNC pattern 8'h2A and a stuffing run of six. With a sixteen-byte buffer, a full-length transfer whose count equals the buffer depth can be reached, together with a split in its middle. The bench decodes the captured line back to bytes and packet boundaries. Its stimulus places a run of six ones at a packet's end, at a split point, and across a split boundary, which tests the stuffing priority and the clearing of the ones run at each SYNC.

// File: rtl/usb_ser_pkg.sv
package usb_ser_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SYNC = 2'd1,
        ST_DATA = 2'd2,
        ST_EOP  = 2'd3
    } ser_state_e;

    // Line symbols as {dp, dn}
    localparam logic [1:0] LN_SE0 = 2'b00;
    localparam logic [1:0] LN_K   = 2'b01;
    localparam logic [1:0] LN_J   = 2'b10;
endpackage

// File: rtl/usb_ser_tick.sv
module usb_ser_tick #(
    parameter int TICKS_PER_BIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic strobe_o
);
    localparam int DIVW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;

    logic [DIVW-1:0] div_d, div_q;

    always_comb begin
        div_d = '0;
        if (run_i) begin
            div_d = (div_q == DIVW'(TICKS_PER_BIT - 1)) ? '0 : div_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign strobe_o = run_i && (div_q == '0);

    // R1: the divider never leaves its range
    a_r1_div_range: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= DIVW'(TICKS_PER_BIT - 1));
endmodule

// File: rtl/usb_ser_nrzi.sv
module usb_ser_nrzi #(
    parameter int STUFF_RUN = 6,
    parameter int OW        = 3
) (
    input  logic [1:0]    line_i,
    input  logic          bit_i,
    input  logic [OW-1:0] ones_i,
    output logic [1:0]    line_o,
    output logic [OW-1:0] ones_o,
    output logic          stuff_o
);
    import usb_ser_pkg::*;

    logic [1:0] flipped;

    always_comb begin
        flipped = (line_i == LN_J) ? LN_K : LN_J;
        stuff_o = (ones_i == OW'(STUFF_RUN));
        if (stuff_o) begin
            line_o = flipped;
            ones_o = '0;
        end else if (bit_i) begin
            line_o = line_i;
            ones_o = ones_i + 1'b1;
        end else begin
            line_o = flipped;
            ones_o = '0;
        end
    end
endmodule

// File: rtl/usb_line_serializer.sv
module usb_line_serializer #(
    parameter int          TICKS_PER_BIT = 4,
    parameter int          MAX_BYTES     = 16,
    parameter logic [7:0]  SYNC_PATTERN  = 8'h2A,
    parameter int          STUFF_RUN     = 6
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               start_i,
    input  logic [$clog2(MAX_BYTES+1)-1:0]     byte_count_i,
    input  logic [$clog2(MAX_BYTES+1)-1:0]     split_idx_i,
    input  logic                               pullup_i,
    output logic [$clog2(MAX_BYTES+1)-1:0]     rd_addr_o,
    input  logic [7:0]                         rd_data_i,
    output logic                               busy_o,
    output logic                               drive_en_o,
    output logic                               dp_o,
    output logic                               dn_o
);
    import usb_ser_pkg::*;

    localparam int IDXW = $clog2(MAX_BYTES + 1);
    localparam int OW   = $clog2(STUFF_RUN + 1);

    typedef struct packed {
        ser_state_e     st;
        logic [2:0]     bitpos;
        logic [IDXW-1:0] byte_idx;
        logic [IDXW-1:0] count;
        logic [IDXW-1:0] split;
        logic           split_pend;
        logic [OW-1:0]  ones;
        logic [1:0]     eop_ph;
        logic [1:0]     line;
        logic           den;
    } ser_regs_t;

    ser_regs_t r_d, r_q;

    logic          strobe;
    logic [1:0]    nz_line;
    logic [OW-1:0] nz_ones;
    logic          nz_stuff;

    usb_ser_tick #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (r_q.st != ST_IDLE),
        .strobe_o (strobe)
    );

    usb_ser_nrzi #(.STUFF_RUN(STUFF_RUN), .OW(OW)) u_nrzi (
        .line_i  (r_q.line),
        .bit_i   (rd_data_i[r_q.bitpos]),
        .ones_i  (r_q.ones),
        .line_o  (nz_line),
        .ones_o  (nz_ones),
        .stuff_o (nz_stuff)
    );

    always_comb begin
        r_d = r_q;
        if (r_q.st == ST_IDLE) begin
            if (start_i) begin
                r_d.st         = ST_SYNC;
                r_d.bitpos     = '0;
                r_d.byte_idx   = '0;
                r_d.count      = byte_count_i;
                r_d.split      = split_idx_i;
                r_d.split_pend = (split_idx_i != '0) && (split_idx_i < byte_count_i);
            end
        end else if (strobe) begin
            unique case (r_q.st)
                ST_SYNC: begin
                    r_d.den    = 1'b1;
                    r_d.ones   = '0;
                    r_d.line   = SYNC_PATTERN[r_q.bitpos] ? LN_J : LN_K;
                    r_d.bitpos = r_q.bitpos + 1'b1;
                    if (r_q.bitpos == 3'd7) r_d.st = ST_DATA;
                end
                ST_DATA: begin
                    if (nz_stuff) begin
                        r_d.line = nz_line;
                        r_d.ones = nz_ones;
                    end else if ((r_q.byte_idx == r_q.count) ||
                                 (r_q.split_pend && (r_q.byte_idx == r_q.split))) begin
                        r_d.line   = LN_SE0;
                        r_d.st     = ST_EOP;
                        r_d.eop_ph = 2'd0;
                    end else begin
                        r_d.line   = nz_line;
                        r_d.ones   = nz_ones;
                        r_d.bitpos = r_q.bitpos + 1'b1;
                        if (r_q.bitpos == 3'd7) r_d.byte_idx = r_q.byte_idx + 1'b1;
                    end
                end
                ST_EOP: begin
                    if (r_q.eop_ph == 2'd0) begin
                        r_d.line   = LN_SE0;
                        r_d.eop_ph = 2'd1;
                    end else if (r_q.eop_ph == 2'd1) begin
                        r_d.line   = LN_J;
                        r_d.eop_ph = 2'd2;
                    end else if (r_q.split_pend) begin
                        r_d.split_pend = 1'b0;
                        r_d.st         = ST_SYNC;
                        r_d.ones       = '0;
                        r_d.line       = SYNC_PATTERN[0] ? LN_J : LN_K;
                        r_d.bitpos     = 3'd1;
                    end else begin
                        r_d.st   = ST_IDLE;
                        r_d.den  = 1'b0;
                        r_d.line = LN_SE0;
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_addr_o  = r_q.byte_idx;
    assign busy_o     = (r_q.st != ST_IDLE);
    assign drive_en_o = r_q.den;
    assign dp_o       = r_q.den ? r_q.line[1] : pullup_i;
    assign dn_o       = r_q.den ? r_q.line[0] : 1'b0;

    // R10: never both lines high
    a_r10_no_se1: assert property (@(posedge clk) disable iff (!rst_n)
        !(dp_o && dn_o));
    // R1: the line only changes on a divider strobe
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !strobe) |=> $stable({drive_en_o, dp_o, dn_o}));
    // R8: start while busy leaves the captured transfer alone
    a_r8_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable({r_q.count, r_q.split}));
    // R8: an accepted start makes the block busy
    a_r8_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);
    // R4: the ones run never exceeds the stuffing limit
    a_r4_ones_bound: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ones <= OW'(STUFF_RUN));
    // R5: release drops the drive together with busy
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !drive_en_o);
    // R7: released line follows the pull-up
    a_r7_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en_o |-> (dp_o == pullup_i) && !dn_o);
endmodule

// File: tb/usb_line_serializer_test.sv
module usb_line_serializer_test;
    localparam int TPB = 4;
    localparam int MB  = 16;
    localparam int IW  = $clog2(MB + 1);
    localparam logic [7:0] PAT = 8'h2A;

    logic clk = 0, rst_n = 0, start_i = 0, pullup_i = 1;
    logic [IW-1:0] byte_count_i = '0, split_idx_i = '0, rd_addr_o;
    logic [7:0] rd_data_i;
    logic busy_o, drive_en_o, dp_o, dn_o;
    logic [7:0] mem [MB];

    int checks = 0, fails = 0, done_cnt = 0;
    bit finished = 0;
    int exp_q[$];
    logic [1:0] sym[$];

    always #5 clk = ~clk;

    assign rd_data_i = (rd_addr_o < IW'(MB)) ? mem[rd_addr_o[3:0]] : 8'h00;

    usb_line_serializer #(.TICKS_PER_BIT(TPB), .MAX_BYTES(MB),
                          .SYNC_PATTERN(PAT), .STUFF_RUN(6)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_count_i(byte_count_i),
        .split_idx_i(split_idx_i), .pullup_i(pullup_i), .rd_addr_o(rd_addr_o),
        .rd_data_i(rd_data_i), .busy_o(busy_o), .drive_en_o(drive_en_o),
        .dp_o(dp_o), .dn_o(dn_o));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pop_cmp(input int got, input string req);
        int e;
        if (exp_q.size() == 0) begin
            chk(0, req, got, -99);
        end else begin
            e = exp_q.pop_front();
            chk(got == e, req, got, e);
        end
    endtask

    // Monitor: decode captured line back into bytes and packet ends
    task automatic decode();
        logic [1:0] g[$];
        int n, ng, i, ones, nb;
        bit uni, se1, ok;
        logic [7:0] cur;
        logic [1:0] prev, s;
        bit b;
        n = sym.size();
        uni = (n % TPB) == 0;
        se1 = 0;
        for (int k = 0; k < n; k++) if (sym[k] == 2'b11) se1 = 1;
        ng = n / TPB;
        for (int gi = 0; gi < ng; gi++) begin
            for (int k = 1; k < TPB; k++) if (sym[gi*TPB+k] != sym[gi*TPB]) uni = 0;
            g.push_back(sym[gi*TPB]);
        end
        chk(uni, "R1 symbol length", n, ng * TPB);
        chk(!se1, "R10 no SE1", se1, 0);
        i = 0;
        while (i < ng) begin
            ok = 1;
            for (int k = 0; k < 8; k++)
                if (i + k >= ng || g[i+k] != (PAT[k] ? 2'b10 : 2'b01)) ok = 0;
            chk(ok, "R2 sync field", ok, 1);
            i += 8;
            prev = g[i-1]; ones = 0; nb = 0; cur = 0;
            while (i < ng && g[i] != 2'b00) begin
                s = g[i];
                b = (s == prev);
                if (ones == 6) begin
                    chk(!b, "R4 stuffed transition", b, 0);
                    ones = 0;
                end else begin
                    cur[nb] = b;
                    nb++;
                    ones = b ? ones + 1 : 0;
                    if (nb == 8) begin
                        pop_cmp(int'(cur), "R3 byte");
                        nb = 0;
                    end
                end
                prev = s;
                i++;
            end
            chk(ones != 6, "R4 stuff before end", ones, 0);
            chk(nb == 0, "R3 whole bytes", nb, 0);
            ok = (i + 2 < ng) && g[i] == 2'b00 && g[i+1] == 2'b00 && g[i+2] == 2'b10;
            chk(ok, "R5 eop shape", ok, 1);
            pop_cmp(-1, "R6 packet boundary");
            i += 3;
        end
    endtask

    always @(negedge clk) begin
        if (drive_en_o) sym.push_back({dp_o, dn_o});
        else if (sym.size() > 0) begin
            decode();
            sym.delete();
            done_cnt++;
        end
    end

    // Driver: load expectations, start, wait for release
    task automatic xfer(input int cnt, input int spl, input logic pu, input bit poke);
        int d0;
        pullup_i = pu;
        for (int b = 0; b < cnt; b++) begin
            if (spl != 0 && spl < cnt && b == spl) exp_q.push_back(-1);
            exp_q.push_back(int'(mem[b]));
        end
        exp_q.push_back(-1);
        d0 = done_cnt;
        @(negedge clk);
        byte_count_i = IW'(cnt); split_idx_i = IW'(spl); start_i = 1;
        @(negedge clk);
        start_i = 0;
        chk(busy_o, "R8 busy after start", busy_o, 1);
        if (poke) begin
            repeat (50) @(negedge clk);
            byte_count_i = IW'(1); split_idx_i = '0; start_i = 1;
            @(negedge clk);
            start_i = 0;
            chk(busy_o, "R8 busy through ignored start", busy_o, 1);
        end
        while (busy_o) @(negedge clk);
        chk(!drive_en_o, "R5 drive off at release", drive_en_o, 0);
        chk(dp_o == pu && !dn_o, "R7 released level", {dp_o, dn_o}, {pu, 1'b0});
        while (done_cnt == d0) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all items seen", exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic load(input logic [7:0] a0, a1, a2, a3, a4, a5);
        mem[0] = a0; mem[1] = a1; mem[2] = a2; mem[3] = a3; mem[4] = a4; mem[5] = a5;
    endtask

    initial begin
        for (int k = 0; k < MB; k++) mem[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy_o && !drive_en_o, "R8 reset idle", busy_o, 0);
        chk(dp_o && !dn_o, "R7 reset level with pullup", {dp_o, dn_o}, 2);
        // R3 plain bytes
        load(8'hA5, 8'h3C, 0, 0, 0, 0);
        xfer(2, 0, 1, 0);
        // R4 heavy stuffing
        load(8'hFF, 8'hFF, 8'hFF, 0, 0, 0);
        xfer(3, 0, 1, 0);
        // R4 six ones end the data: stuff precedes EOP
        load(8'hFC, 0, 0, 0, 0, 0);
        xfer(1, 0, 1, 0);
        // R6 token then data packet
        load(8'h69, 8'h82, 8'h1F, 8'hC3, 8'h11, 8'h22);
        xfer(6, 3, 1, 0);
        // R4 and R9: ones at split, fresh run after SYNC
        load(8'hFC, 8'hFF, 8'h3F, 0, 0, 0);
        xfer(3, 1, 1, 0);
        load(8'hF0, 8'h07, 8'hFE, 0, 0, 0);
        xfer(3, 1, 1, 0);
        // R6 split beyond count gives one packet
        load(8'h5A, 8'h96, 0, 0, 0, 0);
        xfer(2, 5, 1, 0);
        // R8 start while busy ignored
        load(8'h12, 8'h34, 8'h56, 8'h78, 0, 0);
        xfer(4, 0, 1, 1);
        // R7 no pull-up: released line is SE0
        load(8'h00, 8'h80, 0, 0, 0, 0);
        xfer(2, 0, 0, 0);
        // R6 full buffer with split in the middle
        for (int k = 0; k < MB; k++) mem[k] = 8'(k * 37 + 5);
        xfer(MB, 8, 1, 0);
        // R2 zero-length packet: SYNC then EOP
        xfer(0, 0, 1, 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule